// File: doc/BRIEF.md
# Orbit Pulse Conditioner

This block turns a revolution marker into a clean, fixed-length pulse in the domain of a bunch clock. Two asynchronous orbit inputs are each brought into the clock domain through a two-stage synchronizer. Each then passes through an input delay of a whole number of cycles and an edge detector that yields one strobe per rising edge. An internal free-running counter with a programmable period supplies a third strobe source. The strobe of the active source loads a length counter, and the resulting pulse passes through a second, independent delay before it reaches the output.

For a ring channel, the local orbit feeds input A and input B is tied low. For a main-orbit channel, the two ring orbits feed inputs A and B and the internal counter runs on the main bunch clock. The design is configured through a small write-only register port:

- address 0: input delay in bits [3:0] and output delay in bits [7:4];
- address 1: stretch length;
- address 2: counter period;
- address 3: source code in bits [1:0].

A source change is held back until the next event from any source, so switching never cuts a pulse short or creates one.

Top module: `orbit_conditioner`

## Requirements
- R1: While reset is low and after it is released, `orbit_o` is low until a selected event occurs. The reset configuration is: both delays 0, length 1, period 3564, source code 0 (input A).
- R2: With input delay Din and output delay Dout, a rising edge on the selected external input that is applied between two clock edges makes `orbit_o` go high after the (3+Din+Dout)-th clock edge that follows.
- R3: A single rising edge produces exactly one high run on `orbit_o` that lasts L cycles, where L is the length register and L=0 acts as 1. An input held high produces no further pulse.
- R4: A new selected event that arrives while a pulse is high reloads the remaining length to L. Two edges three cycles apart therefore give one run of 3+L cycles.
- R5: Input delay (address 0, bits [3:0]) and output delay (address 0, bits [7:4]) each add 0 to 15 whole cycles, independently of each other.
- R6: With the internal source active and period P>=2, the internal counter produces one event every P cycles. Values below 2 give an event every cycle.
- R7: A write to the period register (address 2) restarts the counter, so the first internal event comes P cycles after the write and the output goes high after the P-th edge following it. The reset period is 3564.
- R8: A new source code takes effect at the first event, from any source, after the write. That event is judged against the previous source.
- R9: Source code 1 selects input B. Edges on input A then have no effect on `orbit_o`.
- R10: Source codes 2 and 3 both select the internal counter. External edges then have no effect on `orbit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| orb_a_i | input | 1 | Asynchronous orbit input A |
| orb_b_i | input | 1 | Asynchronous orbit input B |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register address |
| cfg_wdata_i | input | DATA_W (12) | Configuration write data |
| orbit_o | output | 1 | Conditioned orbit pulse |

## Verification
The assertions assume the following about the inputs:
- the orbit inputs may change at any time, but they only count once sampled at a clock edge;
- configuration writes are single-cycle strobes;
- a period write and a counter wrap in the same cycle resolve to a restart.

The stimulus changes every input on the falling edge, so each change is sampled cleanly by exactly one rising edge. It keeps the input levels low long enough for the longest delay line to drain between trials. It also places period writes so that the internal counter cannot wrap inside an external-input trial unless that wrap is the event being tested.

// File: rtl/orbit_pkg.sv
package orbit_pkg;

  // Source codes: 0 input A, 1 input B, 2 and 3 internal counter.
  typedef enum logic [1:0] {
    SRC_EXT_A   = 2'd0,
    SRC_EXT_B   = 2'd1,
    SRC_INT     = 2'd2,
    SRC_INT_ALT = 2'd3
  } orb_src_e;

  localparam logic [1:0] ADDR_DLY = 2'd0;
  localparam logic [1:0] ADDR_LEN = 2'd1;
  localparam logic [1:0] ADDR_PER = 2'd2;
  localparam logic [1:0] ADDR_SRC = 2'd3;

endpackage

// File: rtl/orbit_cfg_regs.sv
module orbit_cfg_regs
  import orbit_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int DLY_W      = 4,
  parameter int LEN_W      = 8,
  parameter int PER_W      = 12,
  parameter int DEF_PERIOD = 3564
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DLY_W-1:0]  in_dly_o,
  output logic [DLY_W-1:0]  out_dly_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [PER_W-1:0]  period_o,
  output orb_src_e          src_o,
  output logic              period_wr_o
);

  logic [DLY_W-1:0] in_dly_q, in_dly_d, out_dly_q, out_dly_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [PER_W-1:0] per_q, per_d;
  orb_src_e         src_q, src_d;
  logic             wr_dly, wr_len, wr_per, wr_src;

  // Per-register write enables
  always_comb begin
    wr_dly = we_i && (addr_i == ADDR_DLY);
    wr_len = we_i && (addr_i == ADDR_LEN);
    wr_per = we_i && (addr_i == ADDR_PER);
    wr_src = we_i && (addr_i == ADDR_SRC);
  end

  always_comb begin
    in_dly_d  = in_dly_q;
    out_dly_d = out_dly_q;
    len_d     = len_q;
    per_d     = per_q;
    src_d     = src_q;
    if (wr_dly) begin
      in_dly_d  = wdata_i[DLY_W-1:0];
      out_dly_d = wdata_i[2*DLY_W-1:DLY_W];
    end
    if (wr_len) len_d = wdata_i[LEN_W-1:0];
    if (wr_per) per_d = wdata_i[PER_W-1:0];
    if (wr_src) src_d = orb_src_e'(wdata_i[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_dly_q  <= '0;
      out_dly_q <= '0;
      len_q     <= LEN_W'(1);
      per_q     <= PER_W'(DEF_PERIOD);
      src_q     <= SRC_EXT_A;
    end else begin
      in_dly_q  <= in_dly_d;
      out_dly_q <= out_dly_d;
      len_q     <= len_d;
      per_q     <= per_d;
      src_q     <= src_d;
    end
  end

  assign in_dly_o    = in_dly_q;
  assign out_dly_o   = out_dly_q;
  assign len_o       = len_q;
  assign period_o    = per_q;
  assign src_o       = src_q;
  assign period_wr_o = wr_per;

  // R1: configuration holds without a write
  a_r1_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ($stable(per_q) && $stable(len_q) && $stable(src_q) && $stable(in_dly_q)));

endmodule

// File: rtl/orbit_tap_delay.sv
module orbit_tap_delay #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_i,
  input  logic [DLY_W-1:0] sel_i,
  output logic             q_o
);

  localparam int DEPTH = (1 << DLY_W) - 1;

  logic [DEPTH-1:0] sr_q, sr_d;

  always_comb sr_d = {sr_q[DEPTH-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  // Tap 0 is the undelayed input; tap k is k cycles late.
  always_comb q_o = (sel_i == '0) ? d_i : sr_q[sel_i - 1'b1];

  // R5: the first tap follows the input one cycle later
  a_r5_tap_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sr_q[0] == $past(d_i)));

endmodule

// File: rtl/orbit_edge_path.sv
module orbit_edge_path #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             async_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             strobe_o
);

  logic meta_q, sync_q, prev_q, delayed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  orbit_tap_delay #(.DLY_W(DLY_W)) u_in_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sync_q),
    .sel_i (dly_i),
    .q_o   (delayed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= delayed;
  end

  assign strobe_o = delayed & ~prev_q;

  // R3: a held level yields a single strobe
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

endmodule

// File: rtl/orbit_gen.sv
module orbit_gen #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  input  logic             restart_i,
  output logic             wrap_o
);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    wrap_o  = (cnt_inc >= {1'b0, period_i});
    if (restart_i || wrap_o) cnt_d = '0;
    else                     cnt_d = cnt_inc[PER_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: a period write restarts the count
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));

  // R6: the counter advances by one between events
  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !wrap_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/orbit_stretch.sv
module orbit_stretch #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             pulse_o
);

  logic [LEN_W-1:0] rem_q, rem_d, len_eff;

  always_comb begin
    len_eff = (len_i == '0) ? LEN_W'(1) : len_i;
    if (strobe_i)           rem_d = len_eff;
    else if (rem_q != '0)   rem_d = rem_q - 1'b1;
    else                    rem_d = rem_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign pulse_o = (rem_q != '0);

  // R4: every event reloads the full length
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> (rem_q == $past(len_eff)));

  // R3: the run shortens by one each cycle without an event
  a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && rem_q != '0) |=> (rem_q == $past(rem_q) - 1'b1));

endmodule

// File: rtl/orbit_conditioner.sv
module orbit_conditioner
  import orbit_pkg::*;
#(
  parameter int DLY_W      = 4,
  parameter int LEN_W      = 8,
  parameter int PER_W      = 12,
  parameter int DATA_W     = 12,
  parameter int DEF_PERIOD = 3564
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              orb_a_i,
  input  logic              orb_b_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic              orbit_o
);

  localparam int N_EXT = 2;

  logic [DLY_W-1:0] in_dly, out_dly;
  logic [LEN_W-1:0] len;
  logic [PER_W-1:0] period;
  orb_src_e         cfg_src, act_q, act_d;
  logic             period_wr, wrap, any_evt, sel_strobe, pulse;
  logic [N_EXT-1:0] ext_in, ext_evt;

  orbit_cfg_regs #(
    .DATA_W(DATA_W), .DLY_W(DLY_W), .LEN_W(LEN_W),
    .PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .in_dly_o    (in_dly),
    .out_dly_o   (out_dly),
    .len_o       (len),
    .period_o    (period),
    .src_o       (cfg_src),
    .period_wr_o (period_wr)
  );

  assign ext_in = {orb_b_i, orb_a_i};

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    orbit_edge_path #(.DLY_W(DLY_W)) u_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_i  (ext_in[g]),
      .dly_i    (in_dly),
      .strobe_o (ext_evt[g])
    );
  end

  orbit_gen #(.PER_W(PER_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_i  (period),
    .restart_i (period_wr),
    .wrap_o    (wrap)
  );

  // Source change is deferred to an event boundary
  always_comb begin
    any_evt = (|ext_evt) | wrap;
    act_d   = any_evt ? cfg_src : act_q;
    unique case (act_q)
      SRC_EXT_A: sel_strobe = ext_evt[0];
      SRC_EXT_B: sel_strobe = ext_evt[1];
      default:   sel_strobe = wrap;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= SRC_EXT_A;
    else        act_q <= act_d;
  end

  orbit_stretch #(.LEN_W(LEN_W)) u_stretch (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (sel_strobe),
    .len_i    (len),
    .pulse_o  (pulse)
  );

  orbit_tap_delay #(.DLY_W(DLY_W)) u_out_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pulse),
    .sel_i (out_dly),
    .q_o   (orbit_o)
  );

  // R8: the pending source is taken on any event
  a_r8_take: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> (act_q == $past(cfg_src)));

  // R8: no change of source between events
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> $stable(act_q));

endmodule

// File: tb/orbit_conditioner_tb.sv
module orbit_conditioner_tb;
  import orbit_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        orb_a, orb_b, we;
  logic [1:0]  addr;
  logic [11:0] wdata;
  logic        orbit_o;
  int          tests = 0;
  int          fails = 0;
  bit          done  = 1'b0;

  always #10 clk = ~clk;

  orbit_conditioner u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .orb_a_i     (orb_a),
    .orb_b_i     (orb_b),
    .cfg_we_i    (we),
    .cfg_addr_i  (addr),
    .cfg_wdata_i (wdata),
    .orbit_o     (orbit_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = 12'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts negedges from the current one; index of first and second rise, high count
  task automatic observe(input int maxc, output int first, output int second, output int highs);
    logic prev;
    first = -1; second = -1; highs = 0; prev = 1'b0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (orbit_o) begin
        highs++;
        if (!prev) begin
          if (first < 0) first = i;
          else if (second < 0) second = i;
        end
      end
      prev = orbit_o;
    end
  endtask

  // Raise one input, keep it high while observing, then release and drain
  task automatic trial(input bit use_b, output int first, output int highs);
    int second;
    @(negedge clk);
    if (use_b) orb_b = 1'b1; else orb_a = 1'b1;
    observe(60, first, second, highs);
    orb_a = 1'b0; orb_b = 1'b0;
    idle(40);
  endtask

  initial begin
    int f, s, h, e, l;
    rst_n = 1'b0; orb_a = 1'b0; orb_b = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    idle(5);
    rst_n = 1'b1;

    // R1: quiet after reset
    observe(20, f, s, h);
    check("R1", "highs after reset", h, 0);

    // R7 R10: default period 3564 with internal source (code 2)
    wr(ADDR_SRC, 2);
    observe(12000, f, s, h);
    check("R7", "default period spacing", s - f, 3564);

    // R8: switch back to A; the A edge that performs the switch is judged against internal
    wr(ADDR_SRC, 0);
    wr(ADDR_PER, 4095);
    idle(40);
    trial(1'b0, f, h);
    check("R8", "switching edge output", h, 0);

    // R2 R3 R5: delay and length sweep on input A
    for (int d = 0; d < 16; d++) begin
      e = (d * 7) % 16;
      l = 1 + (d % 5);
      wr(ADDR_DLY, (e << 4) | d);
      wr(ADDR_LEN, l);
      idle(40);
      trial(1'b0, f, h);
      check("R5", $sformatf("latency din=%0d dout=%0d", d, e), f, 3 + d + e);
      check("R3", $sformatf("width len=%0d", l), h, l);
    end

    // R3: length 0 acts as 1
    wr(ADDR_DLY, 0);
    wr(ADDR_LEN, 0);
    idle(40);
    trial(1'b0, f, h);
    check("R2", "latency zero delays", f, 3);
    check("R3", "width len=0", h, 1);

    // R9: input B
    wr(ADDR_LEN, 4);
    wr(ADDR_SRC, 1);
    trial(1'b1, f, h);
    check("R8", "B switching edge output", h, 0);
    trial(1'b1, f, h);
    check("R9", "B latency", f, 3);
    check("R9", "B width", h, 4);
    trial(1'b0, f, h);
    check("R9", "A ignored while B active", h, 0);

    // R4: retrigger with edges three cycles apart on B
    wr(ADDR_LEN, 6);
    idle(10);
    f = -1; h = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (orbit_o) begin
        h++;
        if (f < 0) f = i;
      end
      orb_b = (i == 0 || i == 3);
    end
    check("R4", "retrigger first", f, 3);
    check("R4", "retrigger run length", h, 9);
    idle(20);

    // R10 R6 R7: source code 3 is internal; period sweep
    wr(ADDR_LEN, 1);
    wr(ADDR_SRC, 3);
    trial(1'b0, f, h);
    check("R10", "external edge under internal source", h, 0);
    for (int p = 2; p <= 9; p++) begin
      wr(ADDR_PER, p);
      observe(2 * p + 4, f, s, h);
      check("R7", $sformatf("first after restart P=%0d", p), f, p);
      check("R6", $sformatf("second P=%0d", p), s, 2 * p);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule